// File: doc/BRIEF.md
# Interrupt Target Resolver

This unit takes one interrupt request and works out which processor agents it must reach. A request comes in one of two forms. The first is a two-word inter-processor command: a low word carrying the vector, delivery mode, destination mode and shorthand, and a high word carrying the destination byte. The second is a message-signalled interrupt given as an address word and a data word. Both forms are decoded into the same set of request fields. The unit then matches each field set against every agent's physical ID, logical destination byte and addressing-model nibble.

The result is a bitmask with one bit per agent, registered one cycle after the request strobe. For lowest-priority delivery only one agent is chosen: the lowest-indexed agent that matched. Its index is also reported on its own output. The delivery mode, vector and trigger bit are passed through beside the mask, so the per-agent acceptance logic downstream can act on them. The number of agents is a parameter of up to 255. Agents at or beyond that count never appear in the mask.

Top module: `irq_target_resolver`

## Requirements
- R1: In physical mode (destination-mode bit 0), destination 8'hFF selects every agent below N_AGENTS.
- R2: In physical mode, any destination other than 8'hFF selects exactly those agents whose 8-bit physical ID equals the destination.
- R3: In logical mode (destination-mode bit 1), an agent whose model nibble is 4'hF matches when the bitwise AND of the destination and its logical byte is nonzero.
- R4: In logical mode, an agent whose model nibble is 4'h0 matches when the two upper nibbles are equal and the two lower nibbles have at least one set bit in common. An agent with any other model value never matches in logical mode.
- R5: For a command request, bits 19:18 of the low word override addressing: 0 uses the destination fields, 1 selects only the agent at self_idx, 2 selects all agents, 3 selects all agents except self_idx. A self_idx at or beyond N_AGENTS selects nothing for value 1 and removes nothing for value 3.
- R6: For a command request, the destination is high-word bits 31:24. In the low word, the destination mode is bit 11, the delivery mode is bits 10:8, the vector is bits 7:0 and the trigger bit is bit 15.
- R7: For a message request, the destination is address bits 19:12 and the destination mode is address bit 2. In the data word, the vector is bits 7:0, the delivery mode is bits 10:8 and the trigger bit is bit 15. No shorthand applies to a message request.
- R8: When the delivery mode is 3'd1 (lowest priority), the mask holds only the lowest-indexed matching agent, sel_valid is 1 and sel_idx gives that index. If no agent matches, the mask is zero and sel_valid is 0.
- R9: All outputs are registered. They reflect a request one clock after the edge that samples req_valid high. In any cycle after an edge without a request, out_valid, tgt_mask and sel_valid are all zero.
- R10: After reset, out_valid, tgt_mask, sel_valid, sel_idx, out_mode, out_vector and out_trigger are all zero.
- R11: For every delivery mode other than 3'd1 (0 fixed, 2 SMI, 4 NMI, 5 INIT, 6 startup, 7 external, 3 reserved), the full match mask is output, sel_valid stays 0 and out_mode repeats the decoded mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_msi | input | 1 | 1: decode the message address/data words; 0: decode the command words |
| cmd_lo | input | 32 | Command low word |
| cmd_hi | input | 32 | Command high word |
| msi_addr | input | 32 | Message address word |
| msi_data | input | 32 | Message data word |
| self_idx | input | 8 | Index of the requesting agent, used by the shorthand |
| agent_phys_id | input | 8*N_AGENTS | Physical ID of each agent, agent i at bits 8i+7:8i |
| agent_log_byte | input | 8*N_AGENTS | Logical destination byte of each agent |
| agent_model | input | 4*N_AGENTS | Addressing-model nibble of each agent |
| out_valid | output | 1 | Registered result valid |
| tgt_mask | output | N_AGENTS | Agents to deliver to |
| sel_valid | output | 1 | A lowest-priority target was chosen |
| sel_idx | output | 8 | Index of the chosen lowest-priority target |
| out_mode | output | 3 | Decoded delivery mode |
| out_vector | output | 8 | Decoded vector |
| out_trigger | output | 1 | Decoded trigger bit |

## Verification
The assertions assume the agent ID, logical and model inputs are steady around each request. They also assume physical IDs are distinct, so that a physical match selects at most one agent. The stimulus loads one fixed set of distinct IDs before reset is released and never changes it. That set mixes flat, cluster and unrecognised model values, which lets the logical sweeps reach every matching rule. The self index is swept past N_AGENTS on purpose, because the shorthand rule defines what happens in that case.

// File: rtl/irq_resolver_pkg.sv
`timescale 1ns/1ps
package irq_resolver_pkg;

    localparam int VEC_W    = 8;
    localparam int DEST_W   = 8;
    localparam int MODE_W   = 3;
    localparam int MODEL_W  = 4;
    localparam int IDX_W    = 8;

    // command word field positions
    localparam int CMD_DEST_LSB  = 24;   // high word
    localparam int CMD_SH_LSB    = 18;   // low word
    localparam int CMD_TRIG_BIT  = 15;
    localparam int CMD_LOG_BIT   = 11;
    localparam int CMD_MODE_LSB  = 8;

    // message field positions
    localparam int MSG_DEST_LSB  = 12;   // address
    localparam int MSG_LOG_BIT   = 2;    // address
    localparam int MSG_TRIG_BIT  = 15;   // data
    localparam int MSG_MODE_LSB  = 8;    // data

    localparam logic [DEST_W-1:0]  DEST_ALL    = 8'hFF;
    localparam logic [MODEL_W-1:0] MODEL_FLAT  = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUST = 4'h0;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical;
        shorthand_e        shorthand;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
        logic              trigger;
    } req_fields_t;

endpackage

// File: rtl/irq_req_decode.sv
`timescale 1ns/1ps
module irq_req_decode
    import irq_resolver_pkg::*;
(
    input  logic        use_msg,
    input  logic [31:0] cmd_lo,
    input  logic [31:0] cmd_hi,
    input  logic [31:0] msg_addr,
    input  logic [31:0] msg_data,
    output req_fields_t fields
);

    req_fields_t cmd_f;
    req_fields_t msg_f;

    // R6 command word extraction
    always_comb begin
        cmd_f           = '0;
        cmd_f.dest      = cmd_hi[CMD_DEST_LSB +: DEST_W];
        cmd_f.logical   = cmd_lo[CMD_LOG_BIT];
        cmd_f.shorthand = shorthand_e'(cmd_lo[CMD_SH_LSB +: 2]);
        cmd_f.mode      = cmd_lo[CMD_MODE_LSB +: MODE_W];
        cmd_f.vector    = cmd_lo[VEC_W-1:0];
        cmd_f.trigger   = cmd_lo[CMD_TRIG_BIT];
    end

    // R7 message word extraction, no shorthand
    always_comb begin
        msg_f           = '0;
        msg_f.dest      = msg_addr[MSG_DEST_LSB +: DEST_W];
        msg_f.logical   = msg_addr[MSG_LOG_BIT];
        msg_f.shorthand = SH_FIELD;
        msg_f.mode      = msg_data[MSG_MODE_LSB +: MODE_W];
        msg_f.vector    = msg_data[VEC_W-1:0];
        msg_f.trigger   = msg_data[MSG_TRIG_BIT];
    end

    assign fields = use_msg ? msg_f : cmd_f;

endmodule

// File: rtl/irq_agent_match.sv
`timescale 1ns/1ps
module irq_agent_match
    import irq_resolver_pkg::*;
#(
    parameter int N_AGENTS = 8
) (
    input  req_fields_t                  fields,
    input  logic [IDX_W-1:0]             self_idx,
    input  logic [N_AGENTS*DEST_W-1:0]   phys_ids,
    input  logic [N_AGENTS*DEST_W-1:0]   log_bytes,
    input  logic [N_AGENTS*MODEL_W-1:0]  models,
    output logic [N_AGENTS-1:0]          hit_mask
);

    for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
        logic [DEST_W-1:0]  pid;
        logic [DEST_W-1:0]  lb;
        logic [MODEL_W-1:0] mdl;
        logic               phys_hit;
        logic               flat_hit;
        logic               clus_hit;
        logic               addr_hit;
        logic               is_self;

        assign pid = phys_ids[i*DEST_W +: DEST_W];
        assign lb  = log_bytes[i*DEST_W +: DEST_W];
        assign mdl = models[i*MODEL_W +: MODEL_W];

        // R1 R2 physical addressing
        assign phys_hit = (fields.dest == DEST_ALL) || (pid == fields.dest);
        // R3 flat logical
        assign flat_hit = (mdl == MODEL_FLAT) && (|(fields.dest & lb));
        // R4 cluster logical
        assign clus_hit = (mdl == MODEL_CLUST)
                       && (fields.dest[7:4] == lb[7:4])
                       && (|(fields.dest[3:0] & lb[3:0]));

        assign addr_hit = fields.logical ? (flat_hit | clus_hit) : phys_hit;
        assign is_self  = (self_idx == IDX_W'(i));

        // R5 shorthand override
        always_comb begin
            unique case (fields.shorthand)
                SH_FIELD:  hit_mask[i] = addr_hit;
                SH_SELF:   hit_mask[i] = is_self;
                SH_ALL:    hit_mask[i] = 1'b1;
                SH_OTHERS: hit_mask[i] = !is_self;
                default:   hit_mask[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/irq_first_set.sv
`timescale 1ns/1ps
module irq_first_set
    import irq_resolver_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     onehot
);

    // scan from the top so the lowest set bit is written last
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec[k]) begin
                found     = 1'b1;
                idx       = IDX_W'(k);
                onehot    = '0;
                onehot[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_target_resolver.sv
`timescale 1ns/1ps
module irq_target_resolver
    import irq_resolver_pkg::*;
#(
    parameter int N_AGENTS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_msi,
    input  logic [31:0]                 cmd_lo,
    input  logic [31:0]                 cmd_hi,
    input  logic [31:0]                 msi_addr,
    input  logic [31:0]                 msi_data,
    input  logic [7:0]                  self_idx,
    input  logic [N_AGENTS*8-1:0]       agent_phys_id,
    input  logic [N_AGENTS*8-1:0]       agent_log_byte,
    input  logic [N_AGENTS*4-1:0]       agent_model,
    output logic                        out_valid,
    output logic [N_AGENTS-1:0]         tgt_mask,
    output logic                        sel_valid,
    output logic [7:0]                  sel_idx,
    output logic [2:0]                  out_mode,
    output logic [7:0]                  out_vector,
    output logic                        out_trigger
);

    typedef struct packed {
        logic                valid;
        logic [N_AGENTS-1:0] mask;
        logic                sel_valid;
        logic [IDX_W-1:0]    sel_idx;
        logic [MODE_W-1:0]   mode;
        logic [VEC_W-1:0]    vector;
        logic                trigger;
    } res_state_t;

    req_fields_t         fields;
    logic [N_AGENTS-1:0] hit_mask;
    logic                fs_found;
    logic [IDX_W-1:0]    fs_idx;
    logic [N_AGENTS-1:0] fs_onehot;
    res_state_t          state_d;
    res_state_t          state_q;

    irq_req_decode u_decode (
        .use_msg  (req_msi),
        .cmd_lo   (cmd_lo),
        .cmd_hi   (cmd_hi),
        .msg_addr (msi_addr),
        .msg_data (msi_data),
        .fields   (fields)
    );

    irq_agent_match #(.N_AGENTS(N_AGENTS)) u_match (
        .fields    (fields),
        .self_idx  (self_idx),
        .phys_ids  (agent_phys_id),
        .log_bytes (agent_log_byte),
        .models    (agent_model),
        .hit_mask  (hit_mask)
    );

    irq_first_set #(.W(N_AGENTS)) u_first (
        .vec    (hit_mask),
        .found  (fs_found),
        .idx    (fs_idx),
        .onehot (fs_onehot)
    );

    // R8 R9 R11 next-state
    always_comb begin
        state_d = '0;
        if (req_valid) begin
            state_d.valid   = 1'b1;
            state_d.mode    = fields.mode;
            state_d.vector  = fields.vector;
            state_d.trigger = fields.trigger;
            if (fields.mode == DM_LOWEST) begin
                state_d.mask      = fs_onehot;
                state_d.sel_valid = fs_found;
                state_d.sel_idx   = fs_idx;
            end else begin
                state_d.mask = hit_mask;
            end
        end
    end

    // R10 reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.valid;
    assign tgt_mask    = state_q.mask;
    assign sel_valid   = state_q.sel_valid;
    assign sel_idx     = state_q.sel_idx;
    assign out_mode    = state_q.mode;
    assign out_vector  = state_q.vector;
    assign out_trigger = state_q.trigger;

endmodule

// File: rtl/irq_target_resolver_chk.sv
`timescale 1ns/1ps
module irq_target_resolver_chk #(
    parameter int N_AGENTS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_msi,
    input logic [31:0]         cmd_lo,
    input logic [7:0]          self_idx,
    input logic                out_valid,
    input logic [N_AGENTS-1:0] tgt_mask,
    input logic                sel_valid,
    input logic [7:0]          sel_idx,
    input logic [2:0]          out_mode
);

    logic [N_AGENTS-1:0] self_oh;
    logic [N_AGENTS-1:0] sel_oh;
    logic                self_in_range;

    assign self_oh       = N_AGENTS'(1) << self_idx;
    assign sel_oh        = N_AGENTS'(1) << sel_idx;
    assign self_in_range = (32'(self_idx) < N_AGENTS);

    // R9
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (tgt_mask == '0 && !sel_valid));

    // R8
    lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 3'd1) |-> $onehot0(tgt_mask));

    // R8
    sel_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (tgt_mask == sel_oh));

    // R11
    other_mode_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode != 3'd1) |-> !sel_valid);

    // R5
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_msi && cmd_lo[19:18] == 2'd1 && self_in_range)
        |=> (tgt_mask == $past(self_oh)));

    // R5
    others_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_msi && cmd_lo[19:18] == 2'd3)
        |=> ((tgt_mask & $past(self_oh)) == '0));

endmodule

bind irq_target_resolver irq_target_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_msi   (req_msi),
    .cmd_lo    (cmd_lo),
    .self_idx  (self_idx),
    .out_valid (out_valid),
    .tgt_mask  (tgt_mask),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .out_mode  (out_mode)
);

// File: tb/irq_target_resolver_tb.sv
`timescale 1ns/1ps
module irq_target_resolver_tb;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_msi = 1'b0;
    logic [31:0]    cmd_lo = '0;
    logic [31:0]    cmd_hi = '0;
    logic [31:0]    msi_addr = '0;
    logic [31:0]    msi_data = '0;
    logic [7:0]     self_idx = '0;
    logic [N*8-1:0] pid_bus;
    logic [N*8-1:0] lb_bus;
    logic [N*4-1:0] mdl_bus;
    logic           out_valid;
    logic [N-1:0]   tgt_mask;
    logic           sel_valid;
    logic [7:0]     sel_idx;
    logic [2:0]     out_mode;
    logic [7:0]     out_vector;
    logic           out_trigger;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0] cfg_pid [N];
    logic [7:0] cfg_lb  [N];
    logic [3:0] cfg_mdl [N];

    always #5 clk = ~clk;

    irq_target_resolver #(.N_AGENTS(N)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_msi        (req_msi),
        .cmd_lo         (cmd_lo),
        .cmd_hi         (cmd_hi),
        .msi_addr       (msi_addr),
        .msi_data       (msi_data),
        .self_idx       (self_idx),
        .agent_phys_id  (pid_bus),
        .agent_log_byte (lb_bus),
        .agent_model    (mdl_bus),
        .out_valid      (out_valid),
        .tgt_mask       (tgt_mask),
        .sel_valid      (sel_valid),
        .sel_idx        (sel_idx),
        .out_mode       (out_mode),
        .out_vector     (out_vector),
        .out_trigger    (out_trigger)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pid_bus[i*8 +: 8] = cfg_pid[i];
            lb_bus[i*8 +: 8]  = cfg_lb[i];
            mdl_bus[i*4 +: 4] = cfg_mdl[i];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic agent_hit(input int i, input logic [7:0] dest,
                                       input logic lg, input logic [1:0] sh,
                                       input logic [7:0] self);
        logic h;
        case (sh)
            2'd1: h = (int'(self) == i);
            2'd2: h = 1'b1;
            2'd3: h = (int'(self) != i);
            default: begin
                if (!lg) h = (dest == 8'hFF) || (cfg_pid[i] == dest);
                else if (cfg_mdl[i] == 4'hF) h = ((dest & cfg_lb[i]) != 0);
                else if (cfg_mdl[i] == 4'h0)
                    h = (dest[7:4] == cfg_lb[i][7:4]) && ((dest[3:0] & cfg_lb[i][3:0]) != 0);
                else h = 1'b0;
            end
        endcase
        return h;
    endfunction

    task automatic do_req(input logic msi, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] ad, input logic [31:0] da,
                          input logic [7:0] self, input string tag);
        logic [7:0] dest, vec;
        logic [2:0] mode;
        logic [1:0] sh;
        logic lg, trg, e_sel;
        logic [N-1:0] full, e_mask;
        int e_idx;
        if (msi) begin
            dest = ad[19:12]; lg = ad[2]; sh = 2'd0;
            mode = da[10:8]; vec = da[7:0]; trg = da[15];
        end else begin
            dest = hi[31:24]; lg = lo[11]; sh = lo[19:18];
            mode = lo[10:8]; vec = lo[7:0]; trg = lo[15];
        end
        for (int i = 0; i < N; i++) full[i] = agent_hit(i, dest, lg, sh, self);
        e_mask = full; e_sel = 1'b0; e_idx = 0;
        if (mode == 3'd1) begin
            e_mask = '0;
            for (int i = N - 1; i >= 0; i--)
                if (full[i]) begin e_sel = 1'b1; e_idx = i; end
            if (e_sel) e_mask[e_idx] = 1'b1;
        end
        @(negedge clk);
        req_msi = msi; cmd_lo = lo; cmd_hi = hi; msi_addr = ad; msi_data = da;
        self_idx = self; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R9 valid"}, 32'(out_valid), 32'd1);
        chk({tag, " mask"}, 32'(tgt_mask), 32'(e_mask));
        chk({tag, " R8 sel_valid"}, 32'(sel_valid), 32'(e_sel));
        if (e_sel) chk({tag, " R8 sel_idx"}, 32'(sel_idx), 32'(e_idx));
        chk({tag, msi ? " R7 mode" : " R6 R11 mode"}, 32'(out_mode), 32'(mode));
        chk({tag, msi ? " R7 vector" : " R6 vector"}, 32'(out_vector), 32'(vec));
        chk({tag, msi ? " R7 trigger" : " R6 trigger"}, 32'(out_trigger), 32'(trg));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // flat agents 0-3, cluster agents 4-6, unrecognised model on agent 7
        for (int i = 0; i < 4; i++) begin
            cfg_mdl[i] = 4'hF; cfg_lb[i] = 8'(1 << (2 * i));
        end
        cfg_mdl[4] = 4'h0; cfg_lb[4] = 8'h31;
        cfg_mdl[5] = 4'h0; cfg_lb[5] = 8'h36;
        cfg_mdl[6] = 4'h0; cfg_lb[6] = 8'h42;
        cfg_mdl[7] = 4'h5; cfg_lb[7] = 8'hFF;
        for (int i = 0; i < N; i++) cfg_pid[i] = 8'(8'h20 + 5 * i);

        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", 32'(out_valid), 0);
        chk("R10 tgt_mask", 32'(tgt_mask), 0);
        chk("R10 sel_valid", 32'(sel_valid), 0);
        chk("R10 sel_idx", 32'(sel_idx), 0);
        chk("R10 out_mode", 32'(out_mode), 0);
        chk("R10 out_vector", 32'(out_vector), 0);
        chk("R10 out_trigger", 32'(out_trigger), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 physical sweep, mode cycled through all non-lowest values
        for (int d = 0; d < 256; d++) begin
            logic [2:0] m;
            m = 3'(d % 8);
            if (m == 3'd1) m = 3'd3;
            do_req(1'b0, {12'h0, 2'd0, 1'(d), 4'(m << 1) & 4'hE | 4'(m >> 2) & 4'h0, 13'h0} & 32'h0 |
                   (32'(d[0]) << 15) | (32'(m) << 8) | 32'(8'(d) ^ 8'h5A),
                   {8'(d), 24'h0}, 32'h0, 32'h0, 8'd0,
                   (d == 255) ? "R1 physical" : "R2 physical");
        end
        // R3 R4 logical sweep
        for (int d = 0; d < 256; d++)
            do_req(1'b0, (32'(1) << 11) | 32'(8'(d)), {8'(d), 24'h0}, 32'h0, 32'h0,
                   8'd0, "R3 R4 logical");
        // R8 lowest priority over both addressing modes
        for (int d = 0; d < 256; d++)
            do_req(1'b0, (32'(d[0]) << 11) | (32'd1 << 8) | 32'h40, {8'(d), 24'h0},
                   32'h0, 32'h0, 8'd0, "R8 lowest");
        // R5 shorthand, self index including out-of-range values
        for (int sh = 0; sh < 4; sh++)
            for (int s = 0; s < N + 2; s++)
                for (int m = 0; m < 2; m++)
                    do_req(1'b0, (32'(sh) << 18) | (32'(m) << 8) | 32'h77,
                           {8'h20, 24'h0}, 32'h0, 32'h0, 8'(s), "R5 shorthand");
        // R7 message sweep; shorthand bits in the command word must not matter
        for (int d = 0; d < 256; d++)
            do_req(1'b1, 32'h000C_0000, 32'hFF00_0000,
                   32'hFEE0_0000 | (32'(d) << 12) | (32'(d[1]) << 2),
                   (32'(d[0]) << 15) | (32'(d % 8) << 8) | 32'(8'(~d)),
                   8'd0, "R7 message");
        // R9 no strobe: outputs go quiet
        @(negedge clk);
        chk("R9 idle valid", 32'(out_valid), 0);
        chk("R9 idle mask", 32'(tgt_mask), 0);
        chk("R9 idle sel", 32'(sel_valid), 0);
        finish_run();
    end

endmodule